// File: doc/BRIEF.md
# DMA Channel Mode and Software Request Unit

This block holds the per-channel configuration and the software-raised service requests of a four-channel DMA controller. Software writes a byte to a mode port. The low two bits of that byte pick a channel, and the upper six bits become that channel's mode word. The unit decodes each mode word into a service mode, an address direction, an auto-initialise flag and a transfer type, and exports them to the counter and bus-cycle logic that sits outside this block.

A second write port lets software raise or drop a request on any channel. A raised software request behaves like an asserted hardware request line, except that it ignores the mask. It is only honoured while the channel is in block mode. The stored software requests can be read back through a status port. A request is dropped when the outside logic reports terminal count for that channel.

Every cycle, the unit combines the unmasked hardware requests with the qualified software requests. A fixed-priority encoder then names the one channel that should be serviced.

Top module: `dma_modereq_unit`

## Requirements
- R1: A write strobe with port select 00 stores data bits [7:2] as the mode word of the channel named by data bits [1:0]. Only that channel's mode word changes. Each channel exports its service mode from mode bits [7:6] (00 demand, 01 single, 10 block, 11 cascade), its address direction from bit 5 (1 means decrement) and its auto-initialise flag from bit 4.
- R2: Each channel exports its transfer type from mode bits [3:2]. When the service mode is cascade (11), the exported transfer type reads 00, whatever was written.
- R3: A write strobe with port select 01 and data bits [7:3] all zero sets the software request of the channel in data bits [1:0] when data bit 2 is 1, and clears it when data bit 2 is 0. Other channels keep their software requests.
- R4: A port-01 write with any of data bits [7:3] nonzero changes no software request.
- R5: The effective request of channel i is (dreq[i] AND NOT dmask[i]) OR (software request i AND channel i in block mode). A software request is not affected by the mask.
- R6: The grant outputs name the lowest-numbered channel with an effective request, with channel 0 highest. The grant is combinational from the inputs and the stored state. grant_valid is 0 when no channel requests.
- R7: A terminal-count report on a channel clears that channel's software request on the next clock edge. If a valid port-01 write to the same channel arrives in the same cycle, the write decides the bit instead.
- R8: status_data bits [7:4] carry the software requests of channels 3..0 (bit 4+i is channel i), and bits [3:0] read 0.
- R9: Reset clears all mode words and software requests. A master-clear pulse clears all software requests and takes priority over a same-cycle request write. Master clear leaves the mode words unchanged.
- R10: Write strobes with port select 10 or 11 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Master clear pulse for the software requests |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_port | input | 2 | Port select: 00 mode, 01 request |
| wr_data | input | 8 | Written byte |
| dreq | input | NCH | Hardware request lines |
| dmask | input | NCH | Mask for the hardware request lines |
| tc_valid | input | 1 | Terminal count reported this cycle |
| tc_chan | input | CW | Channel reaching terminal count |
| svc_mode | output | 2*NCH | Service mode per channel, channel i at [2i+1:2i] |
| addr_dec | output | NCH | Address direction per channel, 1 = decrement |
| auto_init | output | NCH | Auto-initialise enable per channel |
| xfer_type | output | 2*NCH | Transfer type per channel, 00 when cascade |
| grant_valid | output | 1 | Some channel has an effective request |
| grant_chan | output | CW | Highest-priority requesting channel |
| status_data | output | 8 | Status byte, software requests in [7:4] |

## Verification
The bench builds the unit with its default of four channels. With that default the two-bit channel field of both write ports reaches every channel, and every position of the priority encoder can be exercised. It covers each service mode, including cascade masking the transfer type. It covers collisions between terminal count, master clear and request writes on the same channel and on different channels, with masked and unmasked hardware lines competing against software requests.

// File: rtl/dma_modereq_pkg.sv
package dma_modereq_pkg;

    typedef enum logic [1:0] {
        SVC_DEMAND  = 2'b00,
        SVC_SINGLE  = 2'b01,
        SVC_BLOCK   = 2'b10,
        SVC_CASCADE = 2'b11
    } svc_e;

    localparam logic [1:0] PORT_MODE = 2'b00;
    localparam logic [1:0] PORT_REQ  = 2'b01;

    typedef struct packed {
        svc_e       svc;
        logic       dec;
        logic       autoinit;
        logic [1:0] xfer;
    } mode_t;

endpackage

// File: rtl/dma_mode_bank.sv
module dma_mode_bank
    import dma_modereq_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_chan,
    input  logic [5:0]          wr_word,
    output mode_t [NCH-1:0]     mode_q
);

    typedef struct packed {
        mode_t [NCH-1:0] mode;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode[wr_chan] = mode_t'(wr_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;

    // R1: without a mode write, no mode word moves
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    // R1: the addressed word takes the written value
    p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q[$past(wr_chan)] == mode_t'($past(wr_word))));

endmodule

// File: rtl/dma_swreq_bank.sv
module dma_swreq_bank #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mclr,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_chan,
    input  logic            wr_val,
    input  logic            tc_valid,
    input  logic [CW-1:0]   tc_chan,
    output logic [NCH-1:0]  sw_q
);

    typedef struct packed {
        logic [NCH-1:0] sw;
    } req_t;

    req_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tc_valid) begin
            st_d.sw[tc_chan] = 1'b0;
        end
        if (wr_en) begin
            st_d.sw[wr_chan] = wr_val;
        end
        if (mclr) begin
            st_d.sw = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_q = st_q.sw;

    // R7: terminal count drops the bit unless a write to that channel collides
    p_tc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_valid && !(wr_en && wr_chan == tc_chan)) |=> !sw_q[$past(tc_chan)]);

    // R9: master clear empties every request
    p_mclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (sw_q == '0));

    // R3: an accepted write decides the addressed bit
    p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mclr) |=> (sw_q[$past(wr_chan)] == $past(wr_val)));

endmodule

// File: rtl/dma_prio_enc.sv
module dma_prio_enc #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           valid,
    output logic [CW-1:0]  chan
);

    always_comb begin
        valid = 1'b0;
        chan  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                chan  = CW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_modereq_unit.sv
module dma_modereq_unit
    import dma_modereq_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclr,
    input  logic               wr_stb,
    input  logic [1:0]         wr_port,
    input  logic [7:0]         wr_data,
    input  logic [NCH-1:0]     dreq,
    input  logic [NCH-1:0]     dmask,
    input  logic               tc_valid,
    input  logic [CW-1:0]      tc_chan,
    output logic [2*NCH-1:0]   svc_mode,
    output logic [NCH-1:0]     addr_dec,
    output logic [NCH-1:0]     auto_init,
    output logic [2*NCH-1:0]   xfer_type,
    output logic               grant_valid,
    output logic [CW-1:0]      grant_chan,
    output logic [7:0]         status_data
);

    logic            mode_wr;
    logic            req_wr;
    mode_t [NCH-1:0] mode_q;
    logic [NCH-1:0]  sw_q;
    logic [NCH-1:0]  blk_mode;
    logic [NCH-1:0]  eff_req;

    assign mode_wr = wr_stb && (wr_port == PORT_MODE);
    assign req_wr  = wr_stb && (wr_port == PORT_REQ) && (wr_data[7:3] == 5'b0);

    dma_mode_bank #(.NCH(NCH)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_chan (wr_data[CW-1:0]),
        .wr_word (wr_data[7:2]),
        .mode_q  (mode_q)
    );

    dma_swreq_bank #(.NCH(NCH)) u_swreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (mclr),
        .wr_en    (req_wr),
        .wr_chan  (wr_data[CW-1:0]),
        .wr_val   (wr_data[2]),
        .tc_valid (tc_valid),
        .tc_chan  (tc_chan),
        .sw_q     (sw_q)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            assign svc_mode[2*g +: 2]  = mode_q[g].svc;
            assign addr_dec[g]         = mode_q[g].dec;
            assign auto_init[g]        = mode_q[g].autoinit;
            assign xfer_type[2*g +: 2] = (mode_q[g].svc == SVC_CASCADE) ? 2'b00 : mode_q[g].xfer;
            assign blk_mode[g]         = (mode_q[g].svc == SVC_BLOCK);
        end
    endgenerate

    assign eff_req = (dreq & ~dmask) | (sw_q & blk_mode);

    dma_prio_enc #(.NCH(NCH)) u_prio (
        .req   (eff_req),
        .valid (grant_valid),
        .chan  (grant_chan)
    );

    always_comb begin
        status_data = '0;
        for (int i = 0; i < NCH; i++) begin
            status_data[4+i] = sw_q[i];
        end
    end

    // R6: a granted channel is requesting and no higher one is
    p_grant_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (eff_req[grant_chan] &&
                         ((eff_req & ((NCH'(1) << grant_chan) - NCH'(1))) == '0)));

    // R6: no grant while something requests is an error
    p_grant_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_req != '0) |-> grant_valid);

    // R10: writes to unused ports leave the stored requests alone
    p_unused_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_port[1] && !mclr && !tc_valid) |=> $stable(sw_q));

endmodule

// File: tb/dma_modereq_unit_tb.sv
`timescale 1ns/1ps
module dma_modereq_unit_tb;

    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclr = 1'b0;
    logic       wr_stb = 1'b0;
    logic [1:0] wr_port = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] dreq = 4'h0;
    logic [3:0] dmask = 4'h0;
    logic       tc_valid = 1'b0;
    logic [1:0] tc_chan = 2'b00;
    logic [7:0] svc_mode, xfer_type, status_data;
    logic [3:0] addr_dec, auto_init;
    logic       grant_valid;
    logic [1:0] grant_chan;

    int checks = 0;
    int failures = 0;
    string phase = "R9";

    logic [5:0] m_mode [4];
    logic [3:0] m_sw;

    always #2 clk = ~clk;

    dma_modereq_unit #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .wr_stb(wr_stb),
        .wr_port(wr_port), .wr_data(wr_data), .dreq(dreq), .dmask(dmask),
        .tc_valid(tc_valid), .tc_chan(tc_chan), .svc_mode(svc_mode),
        .addr_dec(addr_dec), .auto_init(auto_init), .xfer_type(xfer_type),
        .grant_valid(grant_valid), .grant_chan(grant_chan),
        .status_data(status_data)
    );

    // behavioural reference of the register state
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_mode[i] <= 6'd0;
            m_sw <= 4'd0;
        end else begin
            logic [3:0] nxt;
            if (wr_stb && wr_port == 2'b00) m_mode[wr_data[1:0]] <= wr_data[7:2];
            nxt = m_sw;
            if (tc_valid) nxt[tc_chan] = 1'b0;
            if (wr_stb && wr_port == 2'b01 && wr_data[7:3] == 5'd0) nxt[wr_data[1:0]] = wr_data[2];
            if (mclr) nxt = 4'd0;
            m_sw <= nxt;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (phase %s) actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] e_svc, e_xf, e_st;
        logic [3:0] e_dec, e_ai, eff;
        logic       e_gv;
        logic [1:0] e_gc;
        e_gv = 1'b0;
        e_gc = 2'd0;
        e_st = 8'd0;
        for (int i = 0; i < 4; i++) begin
            e_svc[2*i +: 2] = m_mode[i][5:4];
            e_dec[i] = m_mode[i][3];
            e_ai[i]  = m_mode[i][2];
            e_xf[2*i +: 2] = (m_mode[i][5:4] == 2'b11) ? 2'b00 : m_mode[i][1:0];
            eff[i] = (dreq[i] & ~dmask[i]) | (m_sw[i] & (m_mode[i][5:4] == 2'b10));
            e_st[4+i] = m_sw[i];
        end
        for (int i = 3; i >= 0; i--) if (eff[i]) begin e_gv = 1'b1; e_gc = 2'(i); end
        chk({svc_mode, addr_dec, auto_init} === {e_svc, e_dec, e_ai}, "R1",
            {16'd0, svc_mode, addr_dec, auto_init}, {16'd0, e_svc, e_dec, e_ai});
        chk(xfer_type === e_xf, "R2", {24'd0, xfer_type}, {24'd0, e_xf});
        chk(status_data === e_st, "R8", {24'd0, status_data}, {24'd0, e_st});
        chk({grant_valid, grant_chan} === {e_gv, e_gc}, "R6",
            {29'd0, grant_valid, grant_chan}, {29'd0, e_gv, e_gc});
    endtask

    task automatic tick();
        @(negedge clk);
        #1 compare();
    endtask

    task automatic wr(input logic [1:0] port, input logic [7:0] data);
        wr_stb = 1'b1; wr_port = port; wr_data = data;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic tc(input logic [1:0] ch);
        tc_valid = 1'b1; tc_chan = ch;
        tick();
        tc_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 compare();                      // R9 reset state
        rst_n = 1'b1;
        tick();

        phase = "R1";
        wr(2'b00, 8'b10_1_1_01_10);        // ch2 block, decrement, autoinit, write
        wr(2'b00, 8'b01_0_1_10_00);        // ch0 single
        phase = "R2";
        wr(2'b00, 8'b11_1_0_10_11);        // ch3 cascade, xfer hidden
        wr(2'b00, 8'b00_0_0_11_01);        // ch1 demand, illegal type visible

        phase = "R3";
        wr(2'b01, 8'b00000_1_10);          // set ch2
        wr(2'b01, 8'b00000_1_00);          // set ch0 (single mode: not serviced)
        phase = "R5";
        dreq = 4'b0010; dmask = 4'b0010; tick();   // masked ch1 loses to ch2 sw
        dmask = 4'b0000; tick();                   // unmasked ch1 wins over ch2
        phase = "R6";
        dreq = 4'b1001; tick();                    // ch0 over ch3
        dreq = 4'b0000; dmask = 4'b1111; tick();   // mask has no hold on sw ch2

        phase = "R4";
        wr(2'b01, 8'b1000_0_010);          // junk bits: ch2 clear ignored
        phase = "R10";
        wr(2'b10, 8'b00000_0_10);
        wr(2'b11, 8'b11_0_0_00_10);

        phase = "R7";
        tc(2'd2);                           // clears ch2
        tc_valid = 1'b1; tc_chan = 2'd0;
        wr(2'b01, 8'b00000_1_00);           // write wins on ch0
        tc_valid = 1'b0;
        wr(2'b01, 8'b00000_1_10);
        tc_valid = 1'b1; tc_chan = 2'd2;
        wr(2'b01, 8'b00000_1_01);           // tc ch2 with write ch1
        tc_valid = 1'b0;

        phase = "R9";
        wr(2'b01, 8'b00000_1_11);
        mclr = 1'b1;
        wr(2'b01, 8'b00000_1_10);           // clear beats write
        mclr = 1'b0;
        tick();

        phase = "R5";
        dmask = 4'b0000;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] d;
            d = 8'($urandom);
            wr_stb   = ($urandom_range(0, 2) == 0);
            wr_port  = 2'($urandom);
            if (wr_port == 2'b01 && $urandom_range(0, 3) != 0) d[7:3] = 5'd0;
            if (wr_port == 2'b00 && $urandom_range(0, 1) == 0) d[7:6] = 2'b10;
            wr_data  = d;
            tc_valid = ($urandom_range(0, 3) == 0);
            tc_chan  = 2'($urandom);
            mclr     = ($urandom_range(0, 40) == 0);
            dreq     = 4'($urandom);
            dmask    = 4'($urandom);
            tick();
        end
        wr_stb = 1'b0; tc_valid = 1'b0; mclr = 1'b0;
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule